// File: doc/BRIEF.md
# FM Data Record Writer

This block assembles one data record for a single-density flexible disk and sends it out as a stream of frequency-modulated half-cells. It starts on a strobe. It first sends a run of zero bytes so that the reader's data separator can lock. Next it sends an address mark byte whose clock pattern lacks three clock pulses, then a fixed-length data field, and then a 16-bit check word. The mark value depends on a flag that says whether the record is normal or deleted.

The data field comes from a byte source through a ready/valid handshake. A count latched at start says how many bytes the source supplies. Any field positions past that count are sent as zero. A one-byte staging register fetches each source byte ahead of the cell stream. If a byte has not arrived when it is due, the stream pauses until it arrives. The check word comes from a CRC register built as its own module. It covers the mark and the field, and it is fed one byte at a time as each byte enters the serialiser.

Each data bit becomes two half-cells: a clock half-cell, then a data half-cell. Bytes go out most significant bit first. The pin `fm_stb_o` pulses once for each half-cell and qualifies `fm_bit_o`. The pin `done_o` pulses once after the record ends.

Top module: `fm_record_writer`

## Requirements
- R1: After start, the block sends PREAMBLE_BYTES zero bytes before the mark, and every clock half-cell in them is 1.
- R2: The mark byte is 0xFB when the deleted flag latched at start is 0, and 0xF8 when it is 1.
- R3: The mark byte's clock pattern is 0xC7, so the clock half-cells for bit positions 5, 4 and 3 (bit 7 = MSB) are 0. All other clock half-cells of the record are 1.
- R4: Each byte is sent as 16 half-cells, MSB first: clock half-cell of bit 7, data half-cell of bit 7, clock half-cell of bit 6, and so on. Each half-cell is marked by one `fm_stb_o` pulse. While source data keeps up, pulses are exactly HALF_CELL_CLKS cycles apart.
- R5: The data field is always FIELD_BYTES bytes. The first min(count, FIELD_BYTES) bytes come from the source, the rest are zero, and exactly that many handshakes take place.
- R6: Two check bytes follow the field, high byte first. They hold the CRC with polynomial x^16+x^12+x^5+1 (0x1021), preset to 0xFFFF and fed MSB first over the mark and the field bytes (the preamble is not included). Feeding mark, field and check bytes through the same CRC gives zero.
- R7: `done_o` is high for exactly one cycle: the cycle after the strobe of the record's last half-cell.
- R8: A start strobe while a record is in progress is ignored. The record keeps its mark, count and length.
- R9: If the next field byte has not arrived when it is due, no strobes occur until it arrives, and the record contents are unchanged.
- R10: During and after reset, and until a start is accepted, `fm_stb_o`, `done_o` and `wr_ready_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Begins a record when the block is idle |
| deleted_i | input | 1 | Selects the deleted-record mark; latched at start |
| count_i | input | $clog2(FIELD_BYTES+1) | Number of source bytes for the field; latched at start |
| wr_data_i | input | 8 | Source byte |
| wr_valid_i | input | 1 | Source byte valid |
| wr_ready_o | output | 1 | Block can accept a source byte |
| fm_bit_o | output | 1 | Current half-cell value |
| fm_stb_o | output | 1 | One pulse per half-cell |
| done_o | output | 1 | One-cycle pulse after the record ends |

## Verification
The bench builds the block with FIELD_BYTES = 16, PREAMBLE_BYTES = 6 and HALF_CELL_CLKS = 2. A short field lets it run full, short, empty and over-length counts without long records. With two clocks per half-cell, the bench can observe both the spacing between strobes and a one-cycle gap after each byte. A slow source that waits 40 cycles between bytes starves the staging register on purpose, which exercises the pause path.

// File: rtl/fmrec_pkg.sv
package fmrec_pkg;

  typedef enum logic [2:0] {
    WS_IDLE, WS_PRE, WS_MARK, WS_FIELD, WS_CHK_HI, WS_CHK_LO, WS_FLUSH
  } wr_state_e;

  localparam logic [15:0] CHK_PRESET    = 16'hFFFF;
  localparam logic [7:0]  MARK_NORMAL   = 8'hFB;
  localparam logic [7:0]  MARK_DELETED  = 8'hF8;
  localparam logic [7:0]  MARK_CLOCKS   = 8'hC7;
  localparam logic [7:0]  PLAIN_CLOCKS  = 8'hFF;

  // One byte through the serial check register: feedback = in ^ top,
  // folded into stages 0, 5 and 12 on each shift.
  function automatic logic [15:0] chk_step_byte(input logic [15:0] cur,
                                                input logic [7:0]  b);
    logic [15:0] r;
    logic fb;
    r = cur;
    for (int i = 7; i >= 0; i--) begin
      fb    = b[i] ^ r[15];
      r     = {r[14:0], 1'b0};
      r[0]  = fb;
      r[5]  = r[5] ^ fb;
      r[12] = r[12] ^ fb;
    end
    return r;
  endfunction

  // Interleave clock and data bits into 16 half-cells, clock first, MSB first.
  function automatic logic [15:0] cell_word(input logic [7:0] data,
                                            input logic [7:0] clks);
    logic [15:0] w;
    for (int i = 0; i < 8; i++) begin
      w[2*i+1] = clks[i];
      w[2*i]   = data[i];
    end
    return w;
  endfunction

  function automatic logic [7:0] mark_value(input logic deleted);
    return deleted ? MARK_DELETED : MARK_NORMAL;
  endfunction

endpackage

// File: rtl/fm_half_cell_timer.sv
module fm_half_cell_timer #(
  parameter int HALF_CELL_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int TW = (HALF_CELL_CLKS > 1) ? $clog2(HALF_CELL_CLKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(HALF_CELL_CLKS - 1);

  logic [TW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R4: the load slot after each byte needs at least two clocks per half-cell
  initial begin
    div_min_chk: assert (HALF_CELL_CLKS >= 2);
  end

  // R10
  idle_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |-> !tick_o);
endmodule

// File: rtl/fm_cell_shifter.sv
module fm_cell_shifter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [15:0] word_i,
  input  logic        tick_i,
  output logic        empty_o,
  output logic        bit_o,
  output logic        stb_o
);
  logic [15:0] sh_q;
  logic [3:0]  pos_q;
  logic        full_q;

  assign empty_o = !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pos_q  <= '0;
      full_q <= 1'b0;
      bit_o  <= 1'b0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (load_i) begin
        sh_q   <= word_i;
        pos_q  <= '0;
        full_q <= 1'b1;
      end else if (tick_i && full_q) begin
        bit_o <= sh_q[15];
        stb_o <= 1'b1;
        sh_q  <= {sh_q[14:0], 1'b0};
        pos_q <= pos_q + 1'b1;
        if (pos_q == 4'd15) full_q <= 1'b0;
      end
    end
  end

  // R4
  load_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !full_q);
  // R4
  stb_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_o |-> $past(tick_i));
endmodule

// File: rtl/fm_chk16.sv
module fm_chk16 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] chk_o
);
  import fmrec_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chk_o <= CHK_PRESET;
    else if (clear_i) chk_o <= CHK_PRESET;
    else if (en_i)    chk_o <= chk_step_byte(chk_o, byte_i);
  end

  // R6
  clear_no_feed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> !clear_i);
endmodule

// File: rtl/fm_record_writer.sv
module fm_record_writer #(
  parameter int PREAMBLE_BYTES = 6,
  parameter int FIELD_BYTES    = 128,
  parameter int HALF_CELL_CLKS = 4,
  localparam int CW = $clog2(FIELD_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          deleted_i,
  input  logic [CW-1:0] count_i,
  input  logic [7:0]    wr_data_i,
  input  logic          wr_valid_i,
  output logic          wr_ready_o,
  output logic          fm_bit_o,
  output logic          fm_stb_o,
  output logic          done_o
);
  import fmrec_pkg::*;

  localparam int IDX_MAX = (FIELD_BYTES > PREAMBLE_BYTES) ? FIELD_BYTES : PREAMBLE_BYTES;
  localparam int KW = $clog2(IDX_MAX + 1);
  localparam logic [KW-1:0] PRE_LAST   = KW'(PREAMBLE_BYTES - 1);
  localparam logic [KW-1:0] FIELD_LAST = KW'(FIELD_BYTES - 1);
  localparam logic [KW-1:0] FIELD_LEN  = KW'(FIELD_BYTES);

  wr_state_e     state_q;
  logic [KW-1:0] idx_q, cnt_lat_q, fetched_q;
  logic          del_lat_q, stage_full_q;
  logic [7:0]    stage_q;

  // internal events, named for the assertions
  logic        busy, start_acc, accept, consume, load, empty, tick, chk_en;
  logic [7:0]  cur_byte;
  logic [15:0] word, chk;

  assign busy       = (state_q != WS_IDLE);
  assign start_acc  = start_i && !busy;
  assign wr_ready_o = busy && !stage_full_q && (fetched_q < cnt_lat_q);
  assign accept     = wr_valid_i && wr_ready_o;

  always_comb begin
    load     = 1'b0;
    consume  = 1'b0;
    chk_en   = 1'b0;
    cur_byte = 8'h00;
    word     = cell_word(8'h00, PLAIN_CLOCKS);
    unique case (state_q)
      WS_PRE:  load = empty;
      WS_MARK: begin
        cur_byte = mark_value(del_lat_q);
        load     = empty;
        chk_en   = load;
        word     = cell_word(cur_byte, MARK_CLOCKS);
      end
      WS_FIELD: begin
        if (idx_q < cnt_lat_q) begin
          cur_byte = stage_q;
          load     = empty && stage_full_q;
          consume  = load;
        end else begin
          load = empty;
        end
        chk_en = load;
        word   = cell_word(cur_byte, PLAIN_CLOCKS);
      end
      WS_CHK_HI: begin
        load = empty;
        word = cell_word(chk[15:8], PLAIN_CLOCKS);
      end
      WS_CHK_LO: begin
        load = empty;
        word = cell_word(chk[7:0], PLAIN_CLOCKS);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= WS_IDLE;
      idx_q     <= '0;
      cnt_lat_q <= '0;
      del_lat_q <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_acc) begin
        state_q   <= WS_PRE;
        idx_q     <= '0;
        del_lat_q <= deleted_i;
        cnt_lat_q <= (KW'(count_i) > FIELD_LEN) ? FIELD_LEN : KW'(count_i);
      end else begin
        unique case (state_q)
          WS_PRE: if (load) begin
            if (idx_q == PRE_LAST) begin idx_q <= '0; state_q <= WS_MARK; end
            else idx_q <= idx_q + 1'b1;
          end
          WS_MARK:   if (load) state_q <= WS_FIELD;
          WS_FIELD: if (load) begin
            if (idx_q == FIELD_LAST) begin idx_q <= '0; state_q <= WS_CHK_HI; end
            else idx_q <= idx_q + 1'b1;
          end
          WS_CHK_HI: if (load) state_q <= WS_CHK_LO;
          WS_CHK_LO: if (load) state_q <= WS_FLUSH;
          WS_FLUSH: if (empty) begin state_q <= WS_IDLE; done_o <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  // one-byte staging register ahead of the serialiser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_full_q <= 1'b0;
      stage_q      <= '0;
      fetched_q    <= '0;
    end else if (start_acc) begin
      stage_full_q <= 1'b0;
      fetched_q    <= '0;
    end else if (accept) begin
      stage_q      <= wr_data_i;
      stage_full_q <= 1'b1;
      fetched_q    <= fetched_q + 1'b1;
    end else if (consume) begin
      stage_full_q <= 1'b0;
    end
  end

  fm_half_cell_timer #(.HALF_CELL_CLKS(HALF_CELL_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(busy), .tick_o(tick));

  fm_cell_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(load), .word_i(word), .tick_i(tick),
    .empty_o(empty), .bit_o(fm_bit_o), .stb_o(fm_stb_o));

  fm_chk16 u_chk (
    .clk(clk), .rst_n(rst_n), .clear_i(start_acc), .en_i(chk_en),
    .byte_i(cur_byte), .chk_o(chk));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  fetch_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetched_q <= cnt_lat_q);
  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ($stable(del_lat_q) && $stable(cnt_lat_q)));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> (!fm_stb_o && !wr_ready_o));
endmodule

// File: tb/tb_fm_record_writer.sv
`timescale 1ns/1ps
module tb_fm_record_writer;
  localparam int PRE = 6;
  localparam int F   = 16;
  localparam int DIV = 2;
  localparam int CW  = $clog2(F + 1);
  localparam int NB  = PRE + 1 + F + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, deleted_i = 0;
  logic [CW-1:0] count_i = '0;
  logic [7:0] wr_data_i = '0;
  logic wr_valid_i = 0;
  logic wr_ready_o, fm_bit_o, fm_stb_o, done_o;

  fm_record_writer #(.PREAMBLE_BYTES(PRE), .FIELD_BYTES(F), .HALF_CELL_CLKS(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .deleted_i(deleted_i),
    .count_i(count_i), .wr_data_i(wr_data_i), .wr_valid_i(wr_valid_i),
    .wr_ready_o(wr_ready_o), .fm_bit_o(fm_bit_o), .fm_stb_o(fm_stb_o),
    .done_o(done_o));

  always #4 clk = ~clk;

  int total = 0, failed = 0;
  logic cells [0:1023];
  int ncell, ndone, cyc, last_stb, done_cyc, prev_stb, gmin, gmax;
  logic [7:0] src [0:31];
  int src_n, src_idx, src_gap, gap_cnt;
  bit src_on = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  always @(negedge clk) begin
    cyc++;
    if (fm_stb_o) begin
      if (ncell < 1024) cells[ncell] = fm_bit_o;
      ncell++;
      if (prev_stb >= 0) begin
        if (cyc - prev_stb < gmin) gmin = cyc - prev_stb;
        if (cyc - prev_stb > gmax) gmax = cyc - prev_stb;
      end
      prev_stb = cyc;
      last_stb = cyc;
    end
    if (done_o) begin ndone++; done_cyc = cyc; end
    if (src_on) begin
      wr_valid_i = (gap_cnt == 0) && (src_idx < src_n);
      wr_data_i  = src[src_idx % 32];
      if (wr_valid_i && wr_ready_o) begin src_idx++; gap_cnt = src_gap; end
      else if (gap_cnt > 0) gap_cnt--;
    end else wr_valid_i = 0;
  end

  function automatic logic [15:0] bcrc(input logic [15:0] c, input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic top = c[15] ^ b[i];
      c = c << 1;
      if (top) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [7:0] dbyte(input int b);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) v[i] = cells[16*b + 2*(7-i) + 1];
    return v;
  endfunction
  function automatic logic [7:0] cbyte(input int b);
    logic [7:0] v;
    for (int i = 7; i >= 0; i--) v[i] = cells[16*b + 2*(7-i)];
    return v;
  endfunction

  task automatic run_record(input bit del, input int cnt, input int nsrc,
                            input int gap, input int inj, input bit tight);
    int eff, bad;
    logic [7:0] exp_mark, expd, a;
    logic [15:0] c;
    for (int i = 0; i < 32; i++) src[i] = 8'($urandom);
    @(negedge clk);
    ncell = 0; ndone = 0; prev_stb = -1; gmin = 1000; gmax = 0;
    src_n = nsrc; src_idx = 0; src_gap = gap; gap_cnt = gap; src_on = 1;
    start_i = 1; deleted_i = del; count_i = CW'(cnt);
    @(negedge clk);
    start_i = 0; deleted_i = 0; count_i = '0;
    if (inj > 0) begin
      repeat (inj) @(negedge clk);
      start_i = 1; deleted_i = !del; count_i = CW'(1);
      @(negedge clk);
      start_i = 0;
    end
    while (ndone == 0) @(negedge clk);
    repeat (6) @(negedge clk);
    src_on = 0;
    eff = (cnt > F) ? F : cnt;
    exp_mark = del ? 8'hF8 : 8'hFB;
    check(ncell == NB*16, "R4", "half-cell count", ncell, NB*16);
    bad = 0;
    for (int b = 0; b < PRE; b++) if (dbyte(b) != 0 || cbyte(b) != 8'hFF) bad++;
    check(bad == 0, "R1", "bad preamble bytes", bad, 0);
    check(dbyte(PRE) == exp_mark, "R2", "mark byte", dbyte(PRE), exp_mark);
    check(cbyte(PRE) == 8'hC7, "R3", "mark clocks", cbyte(PRE), 8'hC7);
    bad = 0;
    for (int b = PRE + 1; b < NB; b++) if (cbyte(b) != 8'hFF) bad++;
    check(bad == 0, "R3", "bytes with missing clocks after mark", bad, 0);
    c = 16'hFFFF;
    c = bcrc(c, exp_mark);
    bad = 0;
    for (int k = 0; k < F; k++) begin
      expd = (k < eff) ? src[k] : 8'h00;
      a = dbyte(PRE + 1 + k);
      if (a != expd) begin
        if (bad == 0) check(0, "R5", $sformatf("field byte %0d", k), a, expd);
        bad++;
      end
      c = bcrc(c, expd);
    end
    if (bad == 0) check(1, "R5", "field bytes", 0, 0);
    check({dbyte(NB-2), dbyte(NB-1)} == c, "R6", "check bytes",
          {dbyte(NB-2), dbyte(NB-1)}, c);
    c = 16'hFFFF;
    for (int b = PRE; b < NB; b++) c = bcrc(c, dbyte(b));
    check(c == 0, "R6", "residual", c, 0);
    check(src_idx == eff, "R5", "handshakes", src_idx, eff);
    check(ndone == 1, "R7", "done pulses", ndone, 1);
    check(done_cyc == last_stb + 1, "R7", "done cycle after last strobe",
          done_cyc - last_stb, 1);
    if (tight) check(gmin == DIV && gmax == DIV, "R4", "strobe spacing max",
                     gmax, DIV);
    else       check(gmax > DIV, "R9", "pause seen (max spacing)", gmax, DIV + 1);
  endtask

  task automatic t_reset();
    int seen = 0;
    repeat (3) @(negedge clk);
    check(!fm_stb_o && !done_o && !wr_ready_o, "R10", "outputs in reset",
          {fm_stb_o, done_o, wr_ready_o}, 0);
    rst_n = 1;
    repeat (8) begin
      @(negedge clk);
      if (fm_stb_o || done_o || wr_ready_o) seen++;
    end
    check(seen == 0, "R10", "activity before start", seen, 0);
  endtask

  task automatic t_normal();      run_record(0, F, F, 0, 0, 1);   endtask
  task automatic t_deleted_short(); run_record(1, 5, 5, 0, 0, 1); endtask
  task automatic t_empty_field(); run_record(0, 0, 0, 0, 0, 1);   endtask
  task automatic t_over_count();  run_record(1, 20, 24, 0, 0, 1); endtask
  task automatic t_busy_start();  // R8
    run_record(0, F, F, 0, 100, 1);
    run_record(1, 3, 3, 0, 500, 1);
  endtask
  task automatic t_stall();       run_record(0, F, F, 40, 0, 0);  endtask  // R9

  initial begin
    t_reset();
    t_normal();
    t_deleted_short();
    t_empty_field();
    t_over_count();
    t_busy_start();
    t_stall();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule